// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block owns a 4 KiB configuration memory and walks the chain of 32-bit extended capability headers in it. The chain starts at byte offset 0x100, and each header carries a 12-bit pointer to the next one. A request either looks up a capability by its identifier or adds a new capability at the end of the chain. A lookup returns the offset of the matching header, the offset of the header before it, and the matching header word. A lookup for an identifier that cannot match, such as any value above 16 bits, stops at the last header and reports it as the predecessor. An append first finds the current tail. It then rewrites only the pointer field of that tail and writes the new header with a zero pointer.

Each request is started by a one-cycle `start`. The result is reported by a one-cycle `done`, which carries all result fields in the same cycle. The memory is a single-port synchronous array, so every visited header costs two cycles: one to issue the read and one to evaluate the data. A word-wide load port fills the memory while no request is running. A hop limit stops a corrupted circular chain, and bad offsets raise `error` instead of being followed.

Top module: `ext_cap_walker`

## Requirements
- R1: After reset, `done`, `found` and `error` are 0, and `rsp_off`, `rsp_prev` and `rsp_hdr` are all zero.
- R2: Header layout is identifier in bits 15:0, version in bits 19:16 and next offset in bits 31:20. A lookup starts at 0x100 and follows next offsets. A lookup is a match when bits 31:16 of `req_id` are zero and bits 15:0 equal the header's identifier. A match gives `found`=1, `rsp_off` = the header offset, `rsp_prev` = the offset of the header before it (0 when the match is at 0x100), and `rsp_hdr` = the header word.
- R3: When the header word at 0x100 is all zeros, a lookup reports an empty chain: `found`=0, `rsp_off`=0, `rsp_prev`=0 and `error`=0.
- R4: A lookup that reaches a header with next offset 0 without matching gives `found`=0, `rsp_off`=0, `rsp_hdr`=0, and `rsp_prev` = the offset of that last header.
- R5: A `req_id` with any of bits 31:16 set never matches, so the lookup returns the chain tail in `rsp_prev`.
- R6: Before reading a header, its offset is checked. The offset must be at least 0x100, at most 4096-8, and a multiple of 4. An offset that fails the check ends the request with `error`=1, and all other result fields are 0.
- R7: After `MAX_HOPS` next offsets have been followed, the next visit ends the request with `error`=1. A circular chain therefore cannot hang the block.
- R8: An append (`op_append`=1) at offset 0x100 writes the header {next=0, `new_ver`, `new_id`} there without walking. It reports `rsp_off`=0x100, `rsp_prev`=0 and `rsp_hdr` = the written word.
- R9: An append at any other offset first locates the tail. It then changes only bits 31:20 of the tail header to the new offset, and finally writes the new header with next=0. It reports `rsp_off` = the new offset, `rsp_prev` = the tail offset and `rsp_hdr` = the new header.
- R10: An append is rejected with `error`=1 and no memory write when any of these holds: `new_size` < 8, `new_off` < 0x100, `new_off` is not a multiple of 4, or `new_off` + `new_size` > 4096.
- R11: An append at an offset other than 0x100 into an empty chain ends with `error`=1 and writes nothing.
- R12: `done` is high for exactly one cycle per accepted request, and `start` is ignored while a request is in progress. The cycle counts are as follows, with a visited header counting as one hop:
  - rejected append: 1 cycle
  - append at 0x100: 2 cycles
  - lookup ending at hop k: 2k+1 cycles
  - append whose tail is hop k: 2k+3 cycles
  - offset or hop-limit fault at hop j: 2j cycles

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a request (one cycle) |
| op_append | input | 1 | 0 = lookup, 1 = append |
| req_id | input | 32 | Identifier to look up |
| new_id | input | 16 | Identifier of the capability to append |
| new_ver | input | 4 | Version of the capability to append |
| new_off | input | 12 | Byte offset of the capability to append |
| new_size | input | 13 | Byte size of the capability to append |
| ld_en | input | 1 | Memory load write enable (used when idle) |
| ld_idx | input | 10 | Word index of the load write |
| ld_data | input | 32 | Load write data |
| done | output | 1 | Result valid pulse |
| found | output | 1 | Lookup matched |
| rsp_off | output | 12 | Result offset |
| rsp_prev | output | 12 | Predecessor or tail offset |
| rsp_hdr | output | 32 | Matched or written header word |
| error | output | 1 | Request failed |

## Verification
Each result is due a fixed number of cycles after `start`, and that number depends only on the chain contents: two cycles per visited header plus one cycle to respond, with two extra write cycles for an append. The bench keeps its own model of the memory, derives both the result fields and this cycle count from the model, and queues them when it drives the request. When `done` appears, the monitor compares the measured distance from `start` against the queued count, along with every field. Any `done` without a queued request, or lasting two cycles, is reported as a failure.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int ID_W  = 16;
  localparam int VER_W = 4;
  localparam int NXT_W = 12;
  localparam int HDR_W = ID_W + VER_W + NXT_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CHECK,
    ST_PATCH,
    ST_HDR
  } walk_st_t;

  function automatic logic [HDR_W-1:0] mk_hdr(input logic [NXT_W-1:0] nxt,
                                             input logic [VER_W-1:0] ver,
                                             input logic [ID_W-1:0]  id);
    return {nxt, ver, id};
  endfunction
endpackage

// File: rtl/cw_cfg_mem.sv
module cw_cfg_mem #(
  parameter int WORDS   = 1024,
  parameter int WORD_AW = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cw_range_chk.sv
module cw_range_chk #(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int OFF_W     = 12,
  parameter int SZ_W      = 13
) (
  input  logic [OFF_W-1:0] off,
  input  logic [SZ_W-1:0]  size,
  output logic             ok
);
  localparam logic [OFF_W-1:0] BASE_L = OFF_W'(BASE_OFF);
  localparam logic [SZ_W-1:0]  MIN_SZ = SZ_W'(8);
  localparam logic [SZ_W:0]    LIMIT  = (SZ_W+1)'(CFG_BYTES);

  logic [SZ_W:0] end_off;
  assign end_off = {{(SZ_W+1-OFF_W){1'b0}}, off} + {1'b0, size};

  assign ok = (off >= BASE_L) && (off[1:0] == 2'b00) &&
              (size >= MIN_SZ) && (end_off <= LIMIT);
endmodule

// File: rtl/cw_walk_ctrl.sv
module cw_walk_ctrl
  import cw_pkg::*;
#(
  parameter int BASE_OFF = 256,
  parameter int MAX_HOPS = 1024,
  parameter int OFF_W    = 12,
  parameter int WORD_AW  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               op_append,
  input  logic [31:0]        req_id,
  input  logic [ID_W-1:0]    new_id,
  input  logic [VER_W-1:0]   new_ver,
  input  logic [OFF_W-1:0]   new_off,
  input  logic               req_ok,
  input  logic               cur_ok,
  input  logic [HDR_W-1:0]   mem_rdata,
  output logic               busy,
  output logic [OFF_W-1:0]   cur_off,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [HDR_W-1:0]   mem_wdata,
  output logic               done,
  output logic               found,
  output logic [OFF_W-1:0]   rsp_off,
  output logic [OFF_W-1:0]   rsp_prev,
  output logic [HDR_W-1:0]   rsp_hdr,
  output logic               error
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);
  localparam logic [HOP_W-1:0]   HOP_LIM = HOP_W'(MAX_HOPS);
  localparam logic [OFF_W-1:0]   BASE_L  = OFF_W'(BASE_OFF);
  localparam logic [WORD_AW-1:0] BASE_W  = WORD_AW'(BASE_OFF / 4);
  localparam int LOW_W = ID_W + VER_W;

  walk_st_t           st;
  logic               app_q;
  logic [31:0]        id_q;
  logic [ID_W-1:0]    nid_q;
  logic [VER_W-1:0]   nver_q;
  logic [OFF_W-1:0]   noff_q;
  logic [OFF_W-1:0]   cur, prev;
  logic [HOP_W-1:0]   hops;
  logic [LOW_W-1:0]   tail_low;

  logic [NXT_W-1:0]   rd_nxt;
  logic               rd_match;
  assign rd_nxt   = mem_rdata[HDR_W-1 -: NXT_W];
  assign rd_match = !app_q && (id_q[31:16] == 16'h0) && (mem_rdata[ID_W-1:0] == id_q[ID_W-1:0]);

  assign busy    = (st != ST_IDLE);
  assign cur_off = cur;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = WORD_AW'(cur >> 2);
    mem_wdata = '0;
    if (st == ST_PATCH) begin
      mem_we    = 1'b1;
      mem_addr  = WORD_AW'(prev >> 2);
      mem_wdata = {noff_q, tail_low};
    end else if (st == ST_HDR) begin
      mem_we    = 1'b1;
      mem_addr  = WORD_AW'(noff_q >> 2);
      mem_wdata = mk_hdr('0, nver_q, nid_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      app_q <= 1'b0; id_q <= '0; nid_q <= '0; nver_q <= '0; noff_q <= '0;
      cur <= '0; prev <= '0; hops <= '0; tail_low <= '0;
      done <= 1'b0; found <= 1'b0; error <= 1'b0;
      rsp_off <= '0; rsp_prev <= '0; rsp_hdr <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start && !done) begin
            app_q  <= op_append;
            id_q   <= req_id;
            nid_q  <= new_id;
            nver_q <= new_ver;
            noff_q <= new_off;
            cur    <= BASE_L;
            prev   <= '0;
            hops   <= '0;
            if (op_append && !req_ok) begin
              done <= 1'b1; error <= 1'b1; found <= 1'b0;
              rsp_off <= '0; rsp_prev <= '0; rsp_hdr <= '0;
            end else if (op_append && new_off == BASE_L) begin
              st <= ST_HDR;
            end else begin
              st <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (!cur_ok || hops == HOP_LIM) begin
            st <= ST_IDLE;
            done <= 1'b1; error <= 1'b1; found <= 1'b0;
            rsp_off <= '0; rsp_prev <= '0; rsp_hdr <= '0;
          end else begin
            st <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (cur == BASE_L && mem_rdata == '0) begin
            st <= ST_IDLE;
            done <= 1'b1; error <= app_q; found <= 1'b0;
            rsp_off <= '0; rsp_prev <= '0; rsp_hdr <= '0;
          end else if (rd_match) begin
            st <= ST_IDLE;
            done <= 1'b1; error <= 1'b0; found <= 1'b1;
            rsp_off <= cur; rsp_prev <= prev; rsp_hdr <= mem_rdata;
          end else if (rd_nxt == '0) begin
            if (app_q) begin
              tail_low <= mem_rdata[LOW_W-1:0];
              prev     <= cur;
              st       <= ST_PATCH;
            end else begin
              st <= ST_IDLE;
              done <= 1'b1; error <= 1'b0; found <= 1'b0;
              rsp_off <= '0; rsp_prev <= cur; rsp_hdr <= '0;
            end
          end else begin
            prev <= cur;
            cur  <= rd_nxt;
            hops <= hops + 1'b1;
            st   <= ST_ISSUE;
          end
        end
        ST_PATCH: st <= ST_HDR;
        ST_HDR: begin
          st <= ST_IDLE;
          done <= 1'b1; error <= 1'b0; found <= 1'b0;
          rsp_off <= noff_q; rsp_prev <= prev;
          rsp_hdr <= mk_hdr('0, nver_q, nid_q);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && error) |-> (!found && rsp_off == '0 && rsp_prev == '0 && rsp_hdr == '0));
  // R2
  found_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> (rsp_off >= BASE_L && rsp_off[1:0] == 2'b00 && !error));
  // R7
  hop_bound_chk: assert property (@(posedge clk) disable iff (rst) busy |-> hops <= HOP_LIM);
  // R10
  wr_above_base_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_addr >= BASE_W);
endmodule

// File: rtl/ext_cap_walker.sv
module ext_cap_walker
  import cw_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MAX_HOPS  = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        op_append,
  input  logic [31:0] req_id,
  input  logic [15:0] new_id,
  input  logic [3:0]  new_ver,
  input  logic [11:0] new_off,
  input  logic [12:0] new_size,
  input  logic        ld_en,
  input  logic [9:0]  ld_idx,
  input  logic [31:0] ld_data,
  output logic        done,
  output logic        found,
  output logic [11:0] rsp_off,
  output logic [11:0] rsp_prev,
  output logic [31:0] rsp_hdr,
  output logic        error
);
  localparam int OFF_W   = NXT_W;
  localparam int SZ_W    = OFF_W + 1;
  localparam int WORDS   = CFG_BYTES / 4;
  localparam int WORD_AW = $clog2(WORDS);

  logic                busy, req_ok, cur_ok;
  logic [OFF_W-1:0]    cur_off;
  logic                c_we, m_we;
  logic [WORD_AW-1:0]  c_addr, m_addr;
  logic [HDR_W-1:0]    c_wdata, m_wdata, m_rdata;
  logic [SZ_W-1:0]     walk_sz;

  assign walk_sz = SZ_W'(8);
  assign m_we    = busy ? c_we    : ld_en;
  assign m_addr  = busy ? c_addr  : ld_idx;
  assign m_wdata = busy ? c_wdata : ld_data;

  cw_cfg_mem #(.WORDS(WORDS), .WORD_AW(WORD_AW), .DATA_W(HDR_W)) u_mem (
    .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata));

  cw_range_chk #(.CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_req_chk (
    .off(new_off), .size(new_size), .ok(req_ok));

  cw_range_chk #(.CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_walk_chk (
    .off(cur_off), .size(walk_sz), .ok(cur_ok));

  cw_walk_ctrl #(.BASE_OFF(BASE_OFF), .MAX_HOPS(MAX_HOPS), .OFF_W(OFF_W), .WORD_AW(WORD_AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_append(op_append), .req_id(req_id),
    .new_id(new_id), .new_ver(new_ver), .new_off(new_off), .req_ok(req_ok), .cur_ok(cur_ok),
    .mem_rdata(m_rdata), .busy(busy), .cur_off(cur_off), .mem_we(c_we), .mem_addr(c_addr),
    .mem_wdata(c_wdata), .done(done), .found(found), .rsp_off(rsp_off), .rsp_prev(rsp_prev),
    .rsp_hdr(rsp_hdr), .error(error));
endmodule

// File: tb/test_ext_cap_walker.sv
module test_ext_cap_walker;
  localparam int HOPS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op_append = 1'b0;
  logic [31:0] req_id = '0;
  logic [15:0] new_id = '0;
  logic [3:0]  new_ver = '0;
  logic [11:0] new_off = '0;
  logic [12:0] new_size = '0;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic        done, found, error;
  logic [11:0] rsp_off, rsp_prev;
  logic [31:0] rsp_hdr;

  always #2.5 clk = ~clk;

  ext_cap_walker #(.MAX_HOPS(HOPS)) i_ext_cap_walker (
    .clk(clk), .rst(rst), .start(start), .op_append(op_append), .req_id(req_id),
    .new_id(new_id), .new_ver(new_ver), .new_off(new_off), .new_size(new_size),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .done(done), .found(found),
    .rsp_off(rsp_off), .rsp_prev(rsp_prev), .rsp_hdr(rsp_hdr), .error(error));

  typedef struct {
    logic        found;
    logic [11:0] off;
    logic [11:0] prev;
    logic [31:0] hdr;
    logic        err;
    int          lat;
    int          st;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mdl [1024];
  int          cyc = 0, checks = 0, errors = 0;
  logic        prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // model lookup; for_app searches the tail only
  function automatic exp_t model_find(input logic [31:0] id, input bit for_app);
    exp_t e;
    int cur = 256, prv = 0, hops = 0, k = 0;
    logic [31:0] h;
    e = '{found: 0, off: 0, prev: 0, hdr: 0, err: 0, lat: 0, st: 0, tag: ""};
    while (1) begin
      k++;
      if (cur < 256 || cur > 4088 || (cur % 4) != 0 || hops == HOPS) begin
        e.err = 1; e.lat = 2 * k; return e;
      end
      h = mdl[cur / 4];
      e.lat = 2 * k + 1;
      if (cur == 256 && h == 0) begin e.err = for_app; return e; end
      if (!for_app && id[31:16] == 0 && h[15:0] == id[15:0]) begin
        e.found = 1; e.off = 12'(cur); e.prev = 12'(prv); e.hdr = h; return e;
      end
      if (h[31:20] == 0) begin e.prev = 12'(cur); return e; end
      prv = cur; cur = int'(h[31:20]); hops++;
    end
  endfunction

  function automatic exp_t model_app(input logic [15:0] id, input logic [3:0] ver,
                                     input int off, input int sz);
    exp_t e, w;
    logic [31:0] nh;
    e = '{found: 0, off: 0, prev: 0, hdr: 0, err: 0, lat: 1, st: 0, tag: ""};
    nh = {12'h0, ver, id};
    if (sz < 8 || off < 256 || (off % 4) != 0 || off + sz > 4096) begin
      e.err = 1; return e;
    end
    if (off == 256) begin
      mdl[64] = nh; e.off = 12'h100; e.hdr = nh; e.lat = 2; return e;
    end
    w = model_find(32'hFFFF_FFFF, 1);
    if (w.err) begin e.err = 1; e.lat = w.lat; return e; end
    mdl[w.prev / 4][31:20] = 12'(off);
    mdl[off / 4] = nh;
    e.off = 12'(off); e.prev = w.prev; e.hdr = nh; e.lat = w.lat + 2;
    return e;
  endfunction

  task automatic send(input bit app, input logic [31:0] id, input logic [15:0] nid,
                      input logic [3:0] nver, input logic [11:0] noff, input logic [12:0] nsz,
                      input exp_t e);
    @(negedge clk);
    op_append = app; req_id = id; new_id = nid; new_ver = nver; new_off = noff; new_size = nsz;
    start = 1'b1;
    e.st = cyc;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_find(input logic [31:0] id, input string tag);
    exp_t e;
    e = model_find(id, 0);
    e.tag = tag;
    send(1'b0, id, 16'h0, 4'h0, 12'h0, 13'h0, e);
  endtask

  task automatic do_app(input logic [15:0] id, input logic [3:0] ver, input int off,
                        input int sz, input string tag);
    exp_t e;
    e = model_app(id, ver, off, sz);
    e.tag = tag;
    send(1'b1, 32'h0, id, ver, 12'(off), 13'(sz), e);
  endtask

  task automatic load(input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 10'(idx); ld_data = d;
    mdl[idx] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      checks++; errors++;
      $display("FAIL R12 watchdog: actual no completion, expected completion");
      summary();
      $finish;
    end
  end

  // monitor: pops expected results as done arrives
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) chk(!done, "R12", $sformatf("done width actual 2+ cycles, expected 1"));
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R12", "unexpected done, actual 1 expected 0");
        end else begin
          exp_t e;
          int lat;
          e = sb.pop_front();
          lat = cyc - e.st;
          chk(found === e.found && rsp_off === e.off && rsp_prev === e.prev &&
              rsp_hdr === e.hdr && error === e.err && lat == e.lat, e.tag,
              $sformatf("actual found=%0b off=%h prev=%h hdr=%h err=%0b lat=%0d expected found=%0b off=%h prev=%h hdr=%h err=%0b lat=%0d",
                        found, rsp_off, rsp_prev, rsp_hdr, error, lat,
                        e.found, e.off, e.prev, e.hdr, e.err, e.lat));
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && found == 0 && error == 0 && rsp_off == 0 && rsp_prev == 0 && rsp_hdr == 0,
        "R1", $sformatf("reset outputs actual done=%0b found=%0b err=%0b off=%h prev=%h hdr=%h expected all 0",
                        done, found, error, rsp_off, rsp_prev, rsp_hdr));

    do_find(32'h0003, "R3 empty chain");
    do_app(16'h0003, 4'h1, 256, 16, "R8 head append");
    do_find(32'h0003, "R2 match at head");
    do_app(16'h000E, 4'h2, 'h140, 16, "R9 append second");
    do_app(16'h0001, 4'h1, 'h200, 8, "R9 append third");
    do_find(32'h0001, "R2 match at third");
    do_find(32'h000E, "R2 match at second");
    do_find(32'h7777, "R4 miss");
    do_find(32'h0001_0003, "R5 wide id");
    do_find(32'hFFFF_FFFF, "R5 sentinel id");

    do_app(16'h0042, 4'h1, 'h300, 4, "R10 size too small");
    do_app(16'h0042, 4'h1, 'h0F0, 8, "R10 below base");
    do_app(16'h0042, 4'h1, 'h302, 8, "R10 misaligned");
    do_app(16'h0042, 4'h1, 'hFF8, 16, "R10 past end");
    do_find(32'hFFFF_FFFF, "R10 tail unchanged");
    do_app(16'h0019, 4'h3, 'hFF8, 8, "R9 R10 last legal slot");
    do_find(32'h0019, "R2 match at last slot");

    // R12: second start during a walk is ignored (it would overwrite the head)
    begin
      exp_t e;
      e = model_find(32'h5555, 0);
      e.tag = "R12 busy start";
      @(negedge clk);
      op_append = 0; req_id = 32'h5555; start = 1'b1;
      e.st = cyc;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      op_append = 1; new_id = 16'hBEEF; new_ver = 4'h7; new_off = 12'h100; new_size = 13'd8;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
    end
    do_find(32'h0003, "R12 head kept after ignored start");

    load(1022, {12'h080, 4'h3, 16'h0019});
    do_find(32'h5555, "R6 next below base");
    load(1022, {12'h206, 4'h3, 16'h0019});
    do_find(32'h5555, "R6 misaligned next");
    load(1022, {12'h140, 4'h3, 16'h0019});
    do_find(32'h5555, "R7 circular chain");
    do_app(16'h0050, 4'h1, 'h400, 8, "R7 circular chain append");
    load(1022, {12'h000, 4'h3, 16'h0019});
    do_find(32'h0019, "R2 chain repaired");

    load(64, 32'h0);
    do_app(16'h0050, 4'h1, 'h400, 8, "R11 append into empty");
    do_find(32'hFFFF_FFFF, "R11 R3 still empty");

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule